// File: doc/BRIEF.md
# Scan-Chain Indirect Register Access Port

This block is a 32-bit test data register that sits behind a TAP controller and gives a debugger indirect access to a bank of 24-bit internal control registers. Each scan carries a write-request bit, a 3-bit block address, a 4-bit register address and a 24-bit data word. The address held in the shift register after one scan is used for a read at the start of the next scan. Reads therefore lag by one scan: scan n returns the register that scan n−1 named. A write takes effect at the end of the scan that carries it.

Writes go out on a simple internal bus as a one-cycle strobe during the update state. If the addressed target reports that it is busy, the write is dropped and a sticky failure flag is set. That flag comes back in bit 31 of the next scan and is cleared when it is captured. The shift register is the only place the address is held.

A two-state controller tracks whether the deferred read is still valid. It has two states:
- `RD_LIVE` (the reset state): the next capture performs the read.
- `RD_STALE`: entered on an instruction-register update (transition *ir_disturb*). The next capture of this register skips the read and returns to `RD_LIVE` (transition *recapture*).

Top module: `scan_route_dr`

## Requirements
- R1: The register shifts one bit per clock while `sel_dr` and `shift_dr` are high. It takes `tdi` into bit 31 and drives bit 0 on `tdo`. Bits 30–24 (block select in 30–28, register number in 27–24) scanned in during one scan come back unchanged in the next scan.
- R2: In capture with `RD_LIVE`, bits 23–0 are loaded with the read data of the target addressed by the previous scan.
- R3: In update with bit 31 = 1, the address decodes and the target is not busy: `bus_we` pulses for exactly one clock with the scanned block, register and data.
- R4: In update with bit 31 = 0, `bus_we` stays low and the target keeps its contents.
- R5: In update with bit 31 = 1, the address decodes and `bus_busy` high: the write is suppressed and the failure flag is set.
- R6: In capture, the failure flag is loaded into bit 31 and then cleared; a 1 means the previous write failed.
- R7: A block number ≥ `BLK_COUNT` or a register number ≥ `REG_COUNT` does not decode. It reads back as zero, gives no `bus_we`, and never sets the failure flag.
- R8: After `ir_update`, the next capture leaves bits 23–0 holding their shifted-in content (state `RD_STALE` → `RD_LIVE`).
- R9: Reset clears the shift register and the failure flag, and enters `RD_LIVE`.
- R10: While `sel_dr` is low, the shift register holds regardless of the other strobes and `tdi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_dr | input | 1 | This data register is selected by the current instruction |
| capture_dr | input | 1 | TAP is in the capture state |
| shift_dr | input | 1 | TAP is in the shift state |
| update_dr | input | 1 | TAP is in the update state |
| ir_update | input | 1 | Instruction register was just updated |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0) |
| bus_blk | output | BLK_W | Block address from the shift register |
| bus_reg | output | REG_W | Register address from the shift register |
| bus_wdata | output | DATA_W | Write data from the shift register |
| bus_we | output | 1 | One-cycle write strobe |
| bus_rdata | input | DATA_W | Read data of the addressed target |
| bus_busy | input | 1 | Addressed target has an action pending |

## Verification
The bench builds the block with `BLK_COUNT` = 5 and `REG_COUNT` = 12. Both the block field and the register field therefore have values that fail to decode, and each out-of-range case can be reached on its own. Random scans spread over all 128 addresses, mixing writes, reads, busy targets, instruction-register updates and idle stretches. This exercises sticky failures across several scans, stale captures, and read-after-write at the same address.

// File: rtl/scan_route_pkg.sv
package scan_route_pkg;

    typedef enum logic {
        RD_LIVE  = 1'b0,
        RD_STALE = 1'b1
    } rd_state_e;

endpackage

// File: rtl/scan_route_decode.sv
module scan_route_decode #(
    parameter int BLK_W     = 3,
    parameter int REG_W     = 4,
    parameter int BLK_COUNT = 5,
    parameter int REG_COUNT = 12
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [REG_W-1:0] rnum,
    output logic             hit
);
    logic blk_ok;
    logic reg_ok;

    generate
        if (BLK_COUNT >= (1 << BLK_W)) begin : g_blk_full
            assign blk_ok = 1'b1;
        end else begin : g_blk_part
            localparam logic [BLK_W:0] BLK_LIM = BLK_COUNT[BLK_W:0];
            assign blk_ok = ({1'b0, blk} < BLK_LIM);
        end
        if (REG_COUNT >= (1 << REG_W)) begin : g_reg_full
            assign reg_ok = 1'b1;
        end else begin : g_reg_part
            localparam logic [REG_W:0] REG_LIM = REG_COUNT[REG_W:0];
            assign reg_ok = ({1'b0, rnum} < REG_LIM);
        end
    endgenerate

    assign hit = blk_ok & reg_ok;

endmodule

// File: rtl/scan_route_flag.sv
module scan_route_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/scan_route_shift.sv
module scan_route_shift #(
    parameter int DR_W   = 32,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              do_read,
    input  logic [DATA_W-1:0] rd_val,
    input  logic              wf_bit,
    input  logic              tdi,
    output logic [DR_W-1:0]   sr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (sel) begin
            if (capture) begin
                sr[DR_W-1] <= wf_bit;
                if (do_read) begin
                    sr[DATA_W-1:0] <= rd_val;
                end
            end else if (shift) begin
                sr <= {tdi, sr[DR_W-1:1]};
            end
        end
    end
endmodule

// File: rtl/scan_route_dr.sv
module scan_route_dr
    import scan_route_pkg::*;
#(
    parameter int BLK_W     = 3,
    parameter int REG_W     = 4,
    parameter int DATA_W    = 24,
    parameter int BLK_COUNT = 5,
    parameter int REG_COUNT = 12
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              sel_dr,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              ir_update,
    input  logic              tdi,
    output logic              tdo,
    output logic [BLK_W-1:0]  bus_blk,
    output logic [REG_W-1:0]  bus_reg,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_busy
);
    localparam int DR_W   = 1 + BLK_W + REG_W + DATA_W;
    localparam int WE_BIT = DR_W - 1;
    localparam int REG_LO = DATA_W;
    localparam int BLK_LO = DATA_W + REG_W;

    logic [DR_W-1:0]   sr;
    logic              hit;
    logic              wf;
    logic              do_read;
    logic              wr_req;
    logic              fail_set;
    logic              cap_sel;
    logic [DATA_W-1:0] rd_val;
    rd_state_e         state_q, state_d;

    // Controller: state register
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_LIVE: begin
                if (ir_update) state_d = RD_STALE;
            end
            RD_STALE: begin
                if (cap_sel && !ir_update) state_d = RD_LIVE;
            end
            default: state_d = RD_LIVE;
        endcase
    end

    // Controller: outputs
    always_comb begin
        do_read = 1'b0;
        unique case (state_q)
            RD_LIVE:  do_read = cap_sel;
            RD_STALE: do_read = 1'b0;
            default:  do_read = 1'b0;
        endcase
    end

    assign cap_sel   = sel_dr & capture_dr;
    assign wr_req    = sel_dr & update_dr & sr[WE_BIT] & hit;
    assign bus_we    = wr_req & ~bus_busy;
    assign fail_set  = wr_req & bus_busy;
    assign rd_val    = hit ? bus_rdata : '0;
    assign bus_blk   = sr[BLK_LO +: BLK_W];
    assign bus_reg   = sr[REG_LO +: REG_W];
    assign bus_wdata = sr[DATA_W-1:0];
    assign tdo       = sr[0];

    scan_route_decode #(
        .BLK_W     (BLK_W),
        .REG_W     (REG_W),
        .BLK_COUNT (BLK_COUNT),
        .REG_COUNT (REG_COUNT)
    ) u_decode (
        .blk  (bus_blk),
        .rnum (bus_reg),
        .hit  (hit)
    );

    scan_route_flag u_flag (
        .clk    (tck),
        .rst_n  (rst_n),
        .set_i  (fail_set),
        .clr_i  (cap_sel),
        .flag_o (wf)
    );

    scan_route_shift #(
        .DR_W   (DR_W),
        .DATA_W (DATA_W)
    ) u_shift (
        .clk     (tck),
        .rst_n   (rst_n),
        .sel     (sel_dr),
        .capture (capture_dr),
        .shift   (shift_dr),
        .do_read (do_read),
        .rd_val  (rd_val),
        .wf_bit  (wf),
        .tdi     (tdi),
        .sr      (sr)
    );

    assert_we_one_cycle_R3: assert property (@(posedge tck) disable iff (!rst_n)
        bus_we |=> !bus_we);

    assert_busy_sets_flag_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (update_dr && sel_dr && sr[WE_BIT] && hit && bus_busy) |=> wf);

    assert_flag_cleared_R6: assert property (@(posedge tck) disable iff (!rst_n)
        cap_sel |=> !wf);

    assert_undecoded_no_we_R7: assert property (@(posedge tck) disable iff (!rst_n)
        bus_we |-> hit);

    assert_read_loads_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_sel && state_q == RD_LIVE) |=> sr[DATA_W-1:0] == $past(rd_val));

    assert_stale_keeps_R8: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_sel && state_q == RD_STALE) |=> $stable(sr[DATA_W-1:0]));

    assert_hold_unselected_R10: assert property (@(posedge tck) disable iff (!rst_n)
        !sel_dr |=> $stable(sr));

endmodule

// File: tb/test_scan_route_dr.sv
`timescale 1ns/1ps
module test_scan_route_dr;
    localparam int BLK_COUNT = 5;
    localparam int REG_COUNT = 12;

    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_dr = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0;
    logic        update_dr = 1'b0, ir_update = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic [2:0]  bus_blk;
    logic [3:0]  bus_reg;
    logic [23:0] bus_wdata;
    logic        bus_we;
    logic [23:0] bus_rdata;
    logic        bus_busy;

    logic [23:0]  tgt_mem [0:127];
    logic [23:0]  exp_mem [0:127];
    logic [127:0] busy_mask = '0;

    int n_tests = 0, n_fail = 0, we_cnt = 0, bad_we = 0, exp_we = 0;
    logic [31:0] prev_in = '0;
    logic        wf_exp = 1'b0;
    logic        stale_exp = 1'b0;

    always #2.5 tck = ~tck;

    assign bus_rdata = tgt_mem[{bus_blk, bus_reg}];
    assign bus_busy  = busy_mask[{bus_blk, bus_reg}];

    scan_route_dr #(.BLK_COUNT(BLK_COUNT), .REG_COUNT(REG_COUNT)) i_scan_route_dr (
        .tck(tck), .rst_n(rst_n), .sel_dr(sel_dr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .ir_update(ir_update),
        .tdi(tdi), .tdo(tdo), .bus_blk(bus_blk), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .bus_busy(bus_busy)
    );

    // Target bank model: applies strobes, flags illegal ones
    always @(posedge tck) begin
        if (bus_we) begin
            if (!hit_ref({bus_blk, bus_reg}) || busy_mask[{bus_blk, bus_reg}]) bad_we++;
            tgt_mem[{bus_blk, bus_reg}] <= bus_wdata;
            we_cnt++;
        end
    end

    function automatic logic hit_ref(logic [6:0] a);
        return (int'(a[6:4]) < BLK_COUNT) && (int'(a[3:0]) < REG_COUNT);
    endfunction

    function automatic logic [31:0] expect_out(logic [31:0] prv, logic wf, logic stale);
        logic [31:0] e;
        e[31]    = wf;
        e[30:24] = prv[30:24];
        if (stale)                  e[23:0] = prv[23:0];
        else if (hit_ref(prv[30:24])) e[23:0] = exp_mem[prv[30:24]];
        else                        e[23:0] = '0;
        return e;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic scan(logic [31:0] din);
        logic [31:0] dout, e;
        string dtag;
        int we_before;
        e = expect_out(prev_in, wf_exp, stale_exp);
        dtag = stale_exp ? "R8" : (hit_ref(prev_in[30:24]) ? "R2" : "R7");
        sel_dr = 1'b1; capture_dr = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 32; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            @(negedge tck);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        we_before = we_cnt;
        @(negedge tck);
        update_dr = 1'b0; sel_dr = 1'b0;
        wf_exp = 1'b0; stale_exp = 1'b0;
        chk("R6 failure bit", {31'd0, dout[31]}, {31'd0, e[31]});
        chk("R1 address echo", {25'd0, dout[30:24]}, {25'd0, e[30:24]});
        chk({dtag, " read data"}, {8'd0, dout[23:0]}, {8'd0, e[23:0]});
        if (din[31] && hit_ref(din[30:24])) begin
            if (busy_mask[din[30:24]]) wf_exp = 1'b1;
            else begin exp_mem[din[30:24]] = din[23:0]; exp_we++; end
        end
        chk(din[31] ? (hit_ref(din[30:24]) ? (busy_mask[din[30:24]] ? "R5 strobe" : "R3 strobe") : "R7 strobe")
                    : "R4 strobe", we_cnt - we_before,
            (din[31] && hit_ref(din[30:24]) && !busy_mask[din[30:24]]) ? 1 : 0);
        prev_in = din;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            shift_dr = 1'($urandom); capture_dr = 1'($urandom);
            update_dr = 1'($urandom); tdi = 1'($urandom);
            @(negedge tck);
            chk("R10 tdo hold", {31'd0, tdo}, {31'd0, prev_in[0]});
        end
        shift_dr = 1'b0; capture_dr = 1'b0; update_dr = 1'b0;
    endtask

    task automatic ir_scan();
        ir_update = 1'b1;
        @(negedge tck);
        ir_update = 1'b0;
        stale_exp = 1'b1;
    endtask

    initial begin
        #(200000.0 * 5.0);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int a = 0; a < 128; a++) begin
            tgt_mem[a] = 24'($urandom);
            exp_mem[a] = tgt_mem[a];
        end
        repeat (3) @(negedge tck);
        rst_n = 1'b1;
        @(negedge tck);
        chk("R9 reset tdo", {31'd0, tdo}, 32'd0);

        // Directed corner cases
        scan({1'b1, 3'd1, 4'd2, 24'hA5A5A5});         // R3 write
        scan({1'b0, 3'd1, 4'd2, 24'h000000});         // R2 read back
        busy_mask[{3'd1, 4'd2}] = 1'b1;
        scan({1'b1, 3'd1, 4'd2, 24'h123456});         // R5 busy write
        scan({1'b0, 3'd1, 4'd2, 24'h0});              // R6 flag seen
        scan({1'b0, 3'd1, 4'd2, 24'h0});              // R6 flag cleared, R5 no change
        busy_mask[{3'd1, 4'd2}] = 1'b0;
        scan({1'b1, 3'd6, 4'd3, 24'hFFFFFF});         // R7 bad block
        scan({1'b1, 3'd2, 4'd13, 24'hFFFFFF});        // R7 bad register
        scan({1'b0, 3'd4, 4'd11, 24'h0});             // edges of decode
        ir_scan();
        scan({1'b0, 3'd0, 4'd0, 24'hC3C3C3});         // R8 stale capture
        idle(5);
        scan({1'b0, 3'd0, 4'd0, 24'h0});              // R10 contents held

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            logic [31:0] d;
            d = $urandom;
            if (($urandom % 4) == 0) busy_mask = {$urandom, $urandom, $urandom, $urandom}
                                               & {$urandom, $urandom, $urandom, $urandom};
            if (($urandom % 10) == 0) ir_scan();
            if (($urandom % 8) == 0) idle(1 + int'($urandom % 4));
            scan(d);
        end
        chk("R3 legal strobes", bad_we, 0);
        chk("R3 strobe total", we_cnt, exp_we);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule